// File: doc/BRIEF.md
# Split Read Completion Reassembler

This block sits behind the receive side of a read-request engine. When a read is issued, the issuing logic records the request against its tag: the dword address it asked for, the number of dwords it expects, and the place in a local buffer memory where the data should go. The completer is free to answer that single request with several smaller completions. The cuts fall on 64-byte or 128-byte address boundaries, so a 23-dword read can come back as 16 dwords followed by 7. The block accepts each completion header (tag, starting dword address, dword count), then the payload dwords that follow it, and writes every dword to the buffer at the correct position.

For each tag the block keeps a running buffer write pointer, the next dword address it expects, and the number of dwords still owed. Partial completions of one request arrive in rising address order, so one running position per tag is enough. Downstream logic therefore sees only a filled buffer region and a one-cycle done pulse carrying the tag. It never sees how the data was split. A completion whose start address does not match, or that names an idle tag, is dropped and flagged. A completion that brings more data than is owed is cut short and flagged.

Top module: `cpl_reassembler`

## Requirements
- R1: After reset, buf_we, done_valid, err_addr and err_ovf are all 0 and no tag is active.
- R2: A cycle with req_valid high makes tag req_tag active and records req_addr as its next expected dword address, req_len as the dwords owed, and req_base as its buffer write pointer.
- R3: A payload dword is accepted when pl_valid is high and dwords of the current completion are still pending. If the completion was accepted, the tag is active and dwords are still owed, the dword appears on buf_data with buf_we high one cycle later. buf_addr equals the tag's write pointer, and the pointer, the next address and the owed count then step by one.
- R4: One request may be satisfied by any number of completions. Each one is accepted when its hdr_addr equals the tag's next expected address, so 16 then 7 dwords fill 23 consecutive buffer words.
- R5: The write of the last owed dword is accompanied in the same cycle by a one-cycle done_valid pulse with done_tag equal to the tag, and the tag becomes inactive.
- R6: A header whose hdr_addr differs from the tag's next expected address, or whose tag is inactive, sets err_addr. None of its payload is written, and the tag's state is left unchanged so that a correct completion can still finish it.
- R7: A header whose hdr_dw exceeds the dwords still owed sets err_ovf. Only the owed dwords are written; the surplus dwords are consumed and discarded.
- R8: Completions for different tags may alternate, completion by completion. Each tag keeps its own write pointer and next address.
- R9: err_addr and err_ovf stay at 1 once set, until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Record a newly issued read request |
| req_tag | input | TAG_W | Tag of the request |
| req_addr | input | ADDR_W | Starting dword address of the request |
| req_len | input | LEN_W | Dwords requested |
| req_base | input | BUF_AW | Buffer word where the request's data begins |
| hdr_valid | input | 1 | Completion header present; taken only when no payload of the previous completion is pending |
| hdr_tag | input | TAG_W | Tag carried by the completion |
| hdr_addr | input | ADDR_W | Dword address of the completion's first dword |
| hdr_dw | input | LEN_W | Dwords in this completion's payload |
| pl_valid | input | 1 | Payload dword present |
| pl_data | input | DATA_W | Payload dword |
| buf_we | output | 1 | Buffer write strobe |
| buf_addr | output | BUF_AW | Buffer word address |
| buf_data | output | DATA_W | Buffer write data |
| done_valid | output | 1 | One-cycle pulse: a request has received all its data |
| done_tag | output | TAG_W | Tag of the finished request |
| err_addr | output | 1 | Sticky: completion address mismatch or idle tag |
| err_ovf | output | 1 | Sticky: completion longer than the dwords owed |

## Verification
The main path is tried in four ways. The first is a 23-dword request split as 16 plus 7, which shows whether the running offset carries across completion boundaries. The second alternates completions of two tags, which shows whether the per-tag positions are kept apart. The third is a single-dword request, where the first dword is also the last one and the done pulse must line up with it. The fourth is a wrong-address completion followed by a correct one, which shows that a rejected completion leaves the tag's state untouched. An oversize completion and a completion to an idle tag check the trimming and drop paths. A behavioural model in the bench is compared with the outputs on every clock, so any shift in timing or position is caught at the cycle where it happens.

// File: rtl/cra_pkg.sv
package cra_pkg;
   typedef enum logic [1:0] {
      HV_ACCEPT  = 2'd0,
      HV_BADADDR = 2'd1,
      HV_OVERRUN = 2'd2
   } hdr_verdict_e;
endpackage

// File: rtl/cra_tag_table.sv
module cra_tag_table #(
   parameter int TAG_W  = 3,
   parameter int ADDR_W = 10,
   parameter int LEN_W  = 10,
   parameter int BUF_AW = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ld_en,
   input  logic [TAG_W-1:0]  ld_tag,
   input  logic [ADDR_W-1:0] ld_addr,
   input  logic [LEN_W-1:0]  ld_len,
   input  logic [BUF_AW-1:0] ld_base,
   input  logic              adv_en,
   input  logic [TAG_W-1:0]  adv_tag,
   input  logic [TAG_W-1:0]  qa_tag,
   output logic              qa_act,
   output logic [ADDR_W-1:0] qa_next,
   output logic [LEN_W-1:0]  qa_rem,
   input  logic [TAG_W-1:0]  qb_tag,
   output logic              qb_act,
   output logic [BUF_AW-1:0] qb_wptr,
   output logic [LEN_W-1:0]  qb_rem
);
   localparam int NTAG = 1 << TAG_W;

   if (TAG_W < 1 || TAG_W > 8) begin : g_bad_tag_w
      $error("cra_tag_table: TAG_W must lie in 1..8");
   end
   if (LEN_W < 1 || ADDR_W < 1 || BUF_AW < 1) begin : g_bad_widths
      $error("cra_tag_table: widths must be positive");
   end

   logic [NTAG-1:0]             act_all;
   logic [NTAG-1:0][ADDR_W-1:0] next_all;
   logic [NTAG-1:0][LEN_W-1:0]  rem_all;
   logic [NTAG-1:0][BUF_AW-1:0] wptr_all;

   for (genvar g = 0; g < NTAG; g++) begin : g_tag
      logic              act_q;
      logic [ADDR_W-1:0] next_q;
      logic [LEN_W-1:0]  rem_q;
      logic [BUF_AW-1:0] wptr_q;
      logic              hit_ld, hit_adv;

      assign hit_ld  = ld_en  && (ld_tag  == TAG_W'(g));
      assign hit_adv = adv_en && (adv_tag == TAG_W'(g));

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            act_q  <= 1'b0;
            next_q <= '0;
            rem_q  <= '0;
            wptr_q <= '0;
         end else if (hit_ld) begin
            act_q  <= (ld_len != '0);
            next_q <= ld_addr;
            rem_q  <= ld_len;
            wptr_q <= ld_base;
         end else if (hit_adv) begin
            act_q  <= (rem_q != LEN_W'(1));
            next_q <= next_q + ADDR_W'(1);
            rem_q  <= rem_q - LEN_W'(1);
            wptr_q <= wptr_q + BUF_AW'(1);
         end
      end

      assign act_all[g]  = act_q;
      assign next_all[g] = next_q;
      assign rem_all[g]  = rem_q;
      assign wptr_all[g] = wptr_q;
   end

   assign qa_act  = act_all[qa_tag];
   assign qa_next = next_all[qa_tag];
   assign qa_rem  = rem_all[qa_tag];
   assign qb_act  = act_all[qb_tag];
   assign qb_wptr = wptr_all[qb_tag];
   assign qb_rem  = rem_all[qb_tag];

   // R7: an advance never reaches a tag that owes nothing
   p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
      adv_en |-> (act_all[adv_tag] && rem_all[adv_tag] != '0));

   // R5: an active tag whose last dword is written is inactive afterwards
   p_free_on_last_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (adv_en && !ld_en && rem_all[adv_tag] == LEN_W'(1)) |=> !act_all[$past(adv_tag)]);
endmodule

// File: rtl/cra_cpl_tracker.sv
module cra_cpl_tracker
   import cra_pkg::*;
#(
   parameter int TAG_W  = 3,
   parameter int ADDR_W = 10,
   parameter int LEN_W  = 10,
   parameter int BUF_AW = 8,
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              hdr_valid,
   input  logic [TAG_W-1:0]  hdr_tag,
   input  logic [ADDR_W-1:0] hdr_addr,
   input  logic [LEN_W-1:0]  hdr_dw,
   input  logic              pl_valid,
   input  logic [DATA_W-1:0] pl_data,
   input  logic              qa_act,
   input  logic [ADDR_W-1:0] qa_next,
   input  logic [LEN_W-1:0]  qa_rem,
   output logic [TAG_W-1:0]  cur_tag,
   input  logic              qb_act,
   input  logic [BUF_AW-1:0] qb_wptr,
   input  logic [LEN_W-1:0]  qb_rem,
   output logic              adv_en,
   output logic              buf_we,
   output logic [BUF_AW-1:0] buf_addr,
   output logic [DATA_W-1:0] buf_data,
   output logic              done_valid,
   output logic [TAG_W-1:0]  done_tag,
   output logic              err_addr,
   output logic              err_ovf
);
   logic [TAG_W-1:0] tag_q;
   logic [LEN_W-1:0] left_q;
   logic             drop_q;
   logic             hdr_take, pl_take, write_ok;
   hdr_verdict_e     verdict;

   assign hdr_take = hdr_valid && (left_q == '0);
   assign pl_take  = pl_valid && (left_q != '0);

   always_comb begin
      if (!qa_act || hdr_addr != qa_next) verdict = HV_BADADDR;
      else if (hdr_dw > qa_rem)           verdict = HV_OVERRUN;
      else                                verdict = HV_ACCEPT;
   end

   assign write_ok = pl_take && !drop_q && qb_act;
   assign adv_en   = write_ok;
   assign cur_tag  = tag_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         tag_q    <= '0;
         left_q   <= '0;
         drop_q   <= 1'b0;
         err_addr <= 1'b0;
         err_ovf  <= 1'b0;
      end else if (hdr_take) begin
         tag_q  <= hdr_tag;
         left_q <= hdr_dw;
         drop_q <= (verdict == HV_BADADDR);
         if (verdict == HV_BADADDR) err_addr <= 1'b1;
         if (verdict == HV_OVERRUN) err_ovf  <= 1'b1;
      end else if (pl_take) begin
         left_q <= left_q - LEN_W'(1);
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         buf_we     <= 1'b0;
         buf_addr   <= '0;
         buf_data   <= '0;
         done_valid <= 1'b0;
         done_tag   <= '0;
      end else begin
         buf_we     <= write_ok;
         done_valid <= write_ok && (qb_rem == LEN_W'(1));
         if (write_ok) begin
            buf_addr <= qb_wptr;
            buf_data <= pl_data;
            done_tag <= tag_q;
         end
      end
   end

   // R9: error flags never clear outside reset
   p_err_addr_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
      err_addr |=> err_addr);
   p_err_ovf_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
      err_ovf |=> err_ovf);
   // R6: a dropped completion produces no write
   p_drop_silent_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (drop_q && pl_valid) |=> !buf_we);
   // R5: done lasts one cycle and comes with a write
   p_done_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
      done_valid |=> !done_valid);
   p_done_with_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
      done_valid |-> buf_we);
endmodule

// File: rtl/cpl_reassembler.sv
module cpl_reassembler #(
   parameter int TAG_W  = 3,
   parameter int ADDR_W = 10,
   parameter int LEN_W  = 10,
   parameter int BUF_AW = 8,
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [TAG_W-1:0]  req_tag,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [LEN_W-1:0]  req_len,
   input  logic [BUF_AW-1:0] req_base,
   input  logic              hdr_valid,
   input  logic [TAG_W-1:0]  hdr_tag,
   input  logic [ADDR_W-1:0] hdr_addr,
   input  logic [LEN_W-1:0]  hdr_dw,
   input  logic              pl_valid,
   input  logic [DATA_W-1:0] pl_data,
   output logic              buf_we,
   output logic [BUF_AW-1:0] buf_addr,
   output logic [DATA_W-1:0] buf_data,
   output logic              done_valid,
   output logic [TAG_W-1:0]  done_tag,
   output logic              err_addr,
   output logic              err_ovf
);
   if (DATA_W < 1) begin : g_bad_data_w
      $error("cpl_reassembler: DATA_W must be positive");
   end

   logic              qa_act, qb_act, adv_en;
   logic [ADDR_W-1:0] qa_next;
   logic [LEN_W-1:0]  qa_rem, qb_rem;
   logic [BUF_AW-1:0] qb_wptr;
   logic [TAG_W-1:0]  cur_tag;

   cra_tag_table #(
      .TAG_W(TAG_W), .ADDR_W(ADDR_W), .LEN_W(LEN_W), .BUF_AW(BUF_AW)
   ) u_table (
      .clk(clk), .rst_n(rst_n),
      .ld_en(req_valid), .ld_tag(req_tag), .ld_addr(req_addr),
      .ld_len(req_len), .ld_base(req_base),
      .adv_en(adv_en), .adv_tag(cur_tag),
      .qa_tag(hdr_tag), .qa_act(qa_act), .qa_next(qa_next), .qa_rem(qa_rem),
      .qb_tag(cur_tag), .qb_act(qb_act), .qb_wptr(qb_wptr), .qb_rem(qb_rem)
   );

   cra_cpl_tracker #(
      .TAG_W(TAG_W), .ADDR_W(ADDR_W), .LEN_W(LEN_W),
      .BUF_AW(BUF_AW), .DATA_W(DATA_W)
   ) u_track (
      .clk(clk), .rst_n(rst_n),
      .hdr_valid(hdr_valid), .hdr_tag(hdr_tag), .hdr_addr(hdr_addr),
      .hdr_dw(hdr_dw), .pl_valid(pl_valid), .pl_data(pl_data),
      .qa_act(qa_act), .qa_next(qa_next), .qa_rem(qa_rem),
      .cur_tag(cur_tag), .qb_act(qb_act), .qb_wptr(qb_wptr), .qb_rem(qb_rem),
      .adv_en(adv_en), .buf_we(buf_we), .buf_addr(buf_addr),
      .buf_data(buf_data), .done_valid(done_valid), .done_tag(done_tag),
      .err_addr(err_addr), .err_ovf(err_ovf)
   );

   // R3: every buffer write follows an offered payload dword
   p_write_follows_payload_r3: assert property (@(posedge clk) disable iff (!rst_n)
      buf_we |-> $past(pl_valid));
endmodule

// File: tb/cpl_reassembler_bench.sv
module cpl_reassembler_bench;
   localparam int TAG_W = 3, ADDR_W = 10, LEN_W = 10, BUF_AW = 8, DATA_W = 32;
   localparam int NTAG = 8, NBUF = 256, NADDR = 1024;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic req_valid = 0, hdr_valid = 0, pl_valid = 0;
   logic [TAG_W-1:0]  req_tag = 0, hdr_tag = 0;
   logic [ADDR_W-1:0] req_addr = 0, hdr_addr = 0;
   logic [LEN_W-1:0]  req_len = 0, hdr_dw = 0;
   logic [BUF_AW-1:0] req_base = 0;
   logic [DATA_W-1:0] pl_data = 0;
   logic              buf_we, done_valid, err_addr, err_ovf;
   logic [BUF_AW-1:0] buf_addr;
   logic [DATA_W-1:0] buf_data;
   logic [TAG_W-1:0]  done_tag;

   always #2 clk = ~clk;  // 250 MHz

   cpl_reassembler #(.TAG_W(TAG_W), .ADDR_W(ADDR_W), .LEN_W(LEN_W),
                     .BUF_AW(BUF_AW), .DATA_W(DATA_W)) u_cpl_reassembler (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_tag(req_tag), .req_addr(req_addr),
      .req_len(req_len), .req_base(req_base),
      .hdr_valid(hdr_valid), .hdr_tag(hdr_tag), .hdr_addr(hdr_addr), .hdr_dw(hdr_dw),
      .pl_valid(pl_valid), .pl_data(pl_data),
      .buf_we(buf_we), .buf_addr(buf_addr), .buf_data(buf_data),
      .done_valid(done_valid), .done_tag(done_tag),
      .err_addr(err_addr), .err_ovf(err_ovf));

   int checks = 0, errors = 0;
   bit finished = 0;

   task automatic check(input bit ok, input string req, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // behavioural reference model
   bit  m_act [NTAG];
   int  m_next[NTAG], m_rem[NTAG], m_wptr[NTAG];
   int  m_tag, m_left;
   bit  m_drop;
   bit  e_we, e_done, e_eaddr, e_eovf;
   int  e_addr, e_tag;
   longint e_data;

   always @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < NTAG; i++) begin
            m_act[i] = 0; m_next[i] = 0; m_rem[i] = 0; m_wptr[i] = 0;
         end
         m_tag = 0; m_left = 0; m_drop = 0;
         e_we = 0; e_done = 0; e_eaddr = 0; e_eovf = 0;
      end else begin
         bit hdr_go, pl_go;
         hdr_go = hdr_valid && m_left == 0;
         pl_go  = pl_valid && m_left != 0;
         e_we = 0; e_done = 0;
         if (hdr_go) begin
            m_tag  = hdr_tag;
            m_left = hdr_dw;
            m_drop = !m_act[hdr_tag] || (int'(hdr_addr) != m_next[hdr_tag]);
            if (m_drop) e_eaddr = 1;
            else if (int'(hdr_dw) > m_rem[hdr_tag]) e_eovf = 1;
         end
         if (pl_go) begin
            m_left--;
            if (!m_drop && m_act[m_tag]) begin
               e_we = 1; e_addr = m_wptr[m_tag]; e_data = pl_data; e_tag = m_tag;
               m_wptr[m_tag] = (m_wptr[m_tag] + 1) % NBUF;
               m_next[m_tag] = (m_next[m_tag] + 1) % NADDR;
               m_rem[m_tag]--;
               if (m_rem[m_tag] == 0) begin
                  m_act[m_tag] = 0; e_done = 1;
               end
            end
         end
         if (req_valid) begin
            m_act[req_tag]  = (req_len != 0);
            m_next[req_tag] = req_addr;
            m_rem[req_tag]  = req_len;
            m_wptr[req_tag] = req_base;
         end
      end
   end

   // per-clock comparison plus capture of the buffer as the port shows it
   logic [DATA_W-1:0] bmem [NBUF];
   int wr_cnt = 0;
   int dcnt [NTAG];
   initial begin
      for (int i = 0; i < NBUF; i++) bmem[i] = '0;
      for (int i = 0; i < NTAG; i++) dcnt[i] = 0;
   end

   always @(negedge clk) begin
      if (rst_n && !finished) begin
         check(buf_we == e_we, "R3 buf_we", buf_we, e_we);
         if (e_we) begin
            check(buf_addr == BUF_AW'(e_addr), "R3 buf_addr", buf_addr, e_addr);
            check(buf_data == DATA_W'(e_data), "R3 buf_data", buf_data, e_data);
         end
         check(done_valid == e_done, "R5 done_valid", done_valid, e_done);
         if (e_done) check(done_tag == TAG_W'(e_tag), "R5 done_tag", done_tag, e_tag);
         check(err_addr == e_eaddr, "R6 err_addr", err_addr, e_eaddr);
         check(err_ovf == e_eovf, "R7 err_ovf", err_ovf, e_eovf);
         if (buf_we) begin
            bmem[buf_addr] = buf_data;
            wr_cnt++;
         end
         if (done_valid) dcnt[done_tag]++;
      end
   end

   task automatic do_req(input int t, input int a, input int l, input int b);
      req_valid = 1; req_tag = TAG_W'(t); req_addr = ADDR_W'(a);
      req_len = LEN_W'(l); req_base = BUF_AW'(b);
      @(negedge clk);
      req_valid = 0;
   endtask

   task automatic do_hdr(input int t, input int a, input int n);
      hdr_valid = 1; hdr_tag = TAG_W'(t); hdr_addr = ADDR_W'(a); hdr_dw = LEN_W'(n);
      @(negedge clk);
      hdr_valid = 0;
   endtask

   task automatic do_pl(input int n, input int seed);
      for (int i = 0; i < n; i++) begin
         pl_valid = 1; pl_data = DATA_W'(seed + i);
         @(negedge clk);
      end
      pl_valid = 0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic summary;
      if (!finished) begin
         finished = 1;
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      checks++; errors++;
      $display("FAIL watchdog expired actual=1 expected=0");
      summary();
   end

   initial begin
      int w0;
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      // R1: quiet outputs after reset
      check(!buf_we && !done_valid, "R1 strobes idle", {buf_we, done_valid}, 0);
      check(!err_addr && !err_ovf, "R1 errors clear", {err_addr, err_ovf}, 0);

      // R2/R4: 23 dwords delivered as 16 + 7
      do_req(1, 100, 23, 0);
      do_hdr(1, 100, 16); do_pl(16, 'h1000);
      do_hdr(1, 116, 7);  do_pl(7, 'h1010);
      idle(2);
      check(bmem[0] == 'h1000, "R2 first word at base", bmem[0], 'h1000);
      check(bmem[15] == 'h100F, "R4 end of first part", bmem[15], 'h100F);
      check(bmem[16] == 'h1010, "R4 start of second part", bmem[16], 'h1010);
      check(bmem[22] == 'h1016, "R4 last word", bmem[22], 'h1016);
      check(dcnt[1] == 1, "R5 one done for split request", dcnt[1], 1);

      // R8: two tags alternating
      do_req(2, 40, 8, 64);
      do_req(3, 200, 4, 96);
      do_hdr(2, 40, 4);  do_pl(4, 'h2000);
      do_hdr(3, 200, 4); do_pl(4, 'h3000);
      do_hdr(2, 44, 4);  do_pl(4, 'h2004);
      idle(2);
      check(bmem[67] == 'h2003, "R8 tag2 first half", bmem[67], 'h2003);
      check(bmem[71] == 'h2007, "R8 tag2 second half", bmem[71], 'h2007);
      check(bmem[99] == 'h3003, "R8 tag3", bmem[99], 'h3003);
      check(dcnt[2] == 1 && dcnt[3] == 1, "R8 both done", dcnt[2] + dcnt[3], 2);

      // R5: single-dword request
      do_req(0, 7, 1, 200);
      do_hdr(0, 7, 1); do_pl(1, 'h4000);
      idle(2);
      check(bmem[200] == 'h4000, "R5 single dword", bmem[200], 'h4000);
      check(dcnt[0] == 1, "R5 single dword done", dcnt[0], 1);

      // R6: wrong address dropped, tag still completes afterwards
      do_req(4, 10, 6, 120);
      w0 = wr_cnt;
      do_hdr(4, 12, 3); do_pl(3, 'h5000);
      idle(2);
      check(wr_cnt == w0, "R6 mismatch not written", wr_cnt, w0);
      check(err_addr == 1, "R6 err_addr set", err_addr, 1);
      do_hdr(4, 10, 6); do_pl(6, 'h5100);
      idle(2);
      check(bmem[120] == 'h5100, "R6 state kept start", bmem[120], 'h5100);
      check(bmem[125] == 'h5105, "R6 state kept end", bmem[125], 'h5105);
      check(dcnt[4] == 1, "R6 tag finished", dcnt[4], 1);

      // R6: idle tag dropped
      w0 = wr_cnt;
      do_hdr(5, 0, 2); do_pl(2, 'h7000);
      idle(2);
      check(wr_cnt == w0, "R6 idle tag not written", wr_cnt, w0);

      // R7: oversize completion trimmed
      check(err_ovf == 0, "R7 no overflow yet", err_ovf, 0);
      do_req(6, 300, 5, 140);
      w0 = wr_cnt;
      do_hdr(6, 300, 8); do_pl(8, 'h6000);
      idle(2);
      check(wr_cnt == w0 + 5, "R7 only owed words written", wr_cnt, w0 + 5);
      check(bmem[144] == 'h6004, "R7 last owed word", bmem[144], 'h6004);
      check(bmem[145] == 0, "R7 surplus discarded", bmem[145], 0);
      check(err_ovf == 1, "R7 err_ovf set", err_ovf, 1);
      check(dcnt[6] == 1, "R7 done once", dcnt[6], 1);

      // R9: flags persist through clean traffic
      do_req(7, 500, 3, 180);
      do_hdr(7, 500, 3); do_pl(3, 'h8000);
      idle(3);
      check(err_addr == 1 && err_ovf == 1, "R9 sticky flags", {err_addr, err_ovf}, 3);
      check(bmem[182] == 'h8002, "R9 clean traffic still works", bmem[182], 'h8002);

      summary();
   end
endmodule